// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block holds a small set of recent virtual-to-physical translations. Every slot stores a lookup key, a physical frame number and a valid flag. A lookup compares the presented key against all slots at the same time. No index bits pick a set, so any translation can sit in any slot. One cycle later the block returns a hit flag and the matching frame, or a miss.

After a miss, the agent that resolves translations (a table walker or system software) writes the missing pair through the fill port. A fill goes into the lowest free slot. When no slot is free, it replaces the slot named by a rotating victim pointer. A fill whose key is already present rewrites that slot in place. A single flush input empties the whole cache in one cycle, for use on a change of address space. The key can be the segment number placed above the page number, so segmented paging can share the cache.

Each cycle the fill logic takes one named action, and the flush decision comes first:
- ACT_IDLE: no change.
- ACT_FLUSH: all slots are cleared.
- ACT_UPDATE: an existing slot is rewritten in place.
- ACT_FREE: the lowest free slot is written.
- ACT_EVICT: the slot under the victim pointer is written and the pointer moves on.

The action is chosen again every cycle, so no action carries over into the next cycle.

Top module: `tlb_assoc`

## Requirements
- R1: Only a slot whose valid flag is set can produce a hit. After reset, and after a flush, every lookup misses.
- R2: A lookup checks the key against all slots at once. A hit returns the frame most recently filled for that key. A miss returns frame value 0.
- R3: The response is registered. `rsp_valid`, `rsp_hit` and `rsp_frame` show the result one cycle after the cycle in which `lk_valid` is high, and `rsp_valid` is low after any cycle without a lookup. A lookup sees the contents as they were before any fill or flush in the same cycle.
- R4: A flush clears the valid flag of every slot in a single cycle.
- R5: A fill whose key matches a valid slot overwrites that slot, so a key is never held twice.
- R6: A fill with a new key, while some slot is free, writes the lowest-numbered free slot.
- R7: A fill with a new key, while every slot is valid, replaces the slot under a victim pointer. The pointer is 0 after reset, moves up by one (wrapping to 0 after the last slot) after each replacement, and is not changed by a flush.
- R8: With `USE_SEG`=1 the key is the segment number placed above the page number. Two requests with the same page number and different segment numbers are different translations.
- R9: When flush and fill are both high in the same cycle, the flush takes effect and the cache is left empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_seg | input | SEG_W | Segment number of the lookup |
| lk_page | input | PAGE_W | Virtual page number of the lookup |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup found a valid slot |
| rsp_frame | output | FRAME_W | Physical frame on a hit, 0 on a miss |
| fill_valid | input | 1 | Load a translation |
| fill_seg | input | SEG_W | Segment number of the fill |
| fill_page | input | PAGE_W | Virtual page number of the fill |
| fill_frame | input | FRAME_W | Physical frame to store |
| flush | input | 1 | Invalidate every slot |

## Verification
Lookups run against an empty cache, a partly filled cache, a full cache and a just-flushed cache. This separates the valid-flag gating from the key compare. Pairs of keys with the same page number and different segment numbers show whether the segment bits take part in the match. A rewrite of a key that is already present shows update in place, as opposed to a second copy. Once the cache is full, the order in which old keys disappear shows both the lowest-free choice and the victim pointer, including that the pointer survives a flush. Cycles where a lookup or a flush coincides with a fill show which contents a lookup sees and which command wins.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_FLUSH,
        ACT_UPDATE,
        ACT_FREE,
        ACT_EVICT
    } fill_act_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int ENTRIES = 16,
    parameter int KEY_W   = 11
) (
    input  logic [KEY_W-1:0]                key,
    input  logic [ENTRIES-1:0]              valid,
    input  logic [ENTRIES-1:0][KEY_W-1:0]   keys,
    output logic [ENTRIES-1:0]              hits
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hits[g] = valid[g] && (keys[g] == key);
    end
endmodule

// File: rtl/tlb_onehot_idx.sv
module tlb_onehot_idx #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4
) (
    input  logic [ENTRIES-1:0] onehot,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (onehot[i]) idx = idx | IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlb_free_pick.sv
module tlb_free_pick #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4
) (
    input  logic [ENTRIES-1:0] valid,
    output logic               any_free,
    output logic [IDX_W-1:0]   idx
);
    always_comb begin
        idx      = '0;
        any_free = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                idx      = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tlb_assoc.sv
module tlb_assoc #(
    parameter int ENTRIES = 16,
    parameter int SEG_W   = 3,
    parameter int PAGE_W  = 8,
    parameter int FRAME_W = 12,
    parameter int USE_SEG = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_valid,
    input  logic [SEG_W-1:0]   lk_seg,
    input  logic [PAGE_W-1:0]  lk_page,
    output logic               rsp_valid,
    output logic               rsp_hit,
    output logic [FRAME_W-1:0] rsp_frame,
    input  logic               fill_valid,
    input  logic [SEG_W-1:0]   fill_seg,
    input  logic [PAGE_W-1:0]  fill_page,
    input  logic [FRAME_W-1:0] fill_frame,
    input  logic               flush
);
    import tlb_pkg::*;

    localparam int KEY_W = SEG_W + PAGE_W;
    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0]              valid_q;
    logic [ENTRIES-1:0][KEY_W-1:0]   key_q;
    logic [ENTRIES-1:0][FRAME_W-1:0] frame_q;
    logic [IDX_W-1:0]                rr_q;

    logic [KEY_W-1:0]   lk_key, fill_key;
    logic [ENTRIES-1:0] lk_hits, fill_hits;
    logic [IDX_W-1:0]   lk_idx, upd_idx, free_idx, wr_idx;
    logic               free_any, lk_found;
    fill_act_e          act;

    assign lk_key   = {(USE_SEG != 0) ? lk_seg : '0, lk_page};
    assign fill_key = {(USE_SEG != 0) ? fill_seg : '0, fill_page};

    tlb_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_lk_match (
        .key(lk_key), .valid(valid_q), .keys(key_q), .hits(lk_hits)
    );
    tlb_match #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_fill_match (
        .key(fill_key), .valid(valid_q), .keys(key_q), .hits(fill_hits)
    );
    tlb_onehot_idx #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_lk_idx (
        .onehot(lk_hits), .idx(lk_idx)
    );
    tlb_onehot_idx #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_upd_idx (
        .onehot(fill_hits), .idx(upd_idx)
    );
    tlb_free_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_free (
        .valid(valid_q), .any_free(free_any), .idx(free_idx)
    );

    assign lk_found = lk_valid && (|lk_hits);

    // Action decision: flush outranks any fill.
    always_comb begin
        if (flush)              act = ACT_FLUSH;
        else if (!fill_valid)   act = ACT_IDLE;
        else if (|fill_hits)    act = ACT_UPDATE;
        else if (free_any)      act = ACT_FREE;
        else                    act = ACT_EVICT;
    end

    always_comb begin
        unique case (act)
            ACT_UPDATE: wr_idx = upd_idx;
            ACT_FREE:   wr_idx = free_idx;
            ACT_EVICT:  wr_idx = rr_q;
            default:    wr_idx = '0;
        endcase
    end

    // State: valid flags and victim pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else begin
            unique case (act)
                ACT_FLUSH: valid_q <= '0;
                ACT_UPDATE, ACT_FREE: valid_q[wr_idx] <= 1'b1;
                ACT_EVICT: begin
                    valid_q[wr_idx] <= 1'b1;
                    rr_q <= (rr_q == LAST_IDX) ? '0 : rr_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Payload storage, no reset needed.
    always_ff @(posedge clk) begin
        if (act == ACT_UPDATE || act == ACT_FREE || act == ACT_EVICT) begin
            key_q[wr_idx]   <= fill_key;
            frame_q[wr_idx] <= fill_frame;
        end
    end

    // Registered lookup response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_frame <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_found;
            rsp_frame <= lk_found ? frame_q[lk_idx] : '0;
        end
    end
endmodule

// File: rtl/tlb_assoc_chk.sv
module tlb_assoc_chk #(
    parameter int ENTRIES = 16,
    parameter int FRAME_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic               fill_valid,
    input logic               flush,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [FRAME_W-1:0] rsp_frame,
    input logic [ENTRIES-1:0] valid_q,
    input logic [ENTRIES-1:0] lk_hits
);
    AST_HIT_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid); // R1
    AST_MISS_FRAME_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_frame == '0)); // R2
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid); // R3
    AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid); // R3
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0)); // R4
    AST_NO_DUP_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hits)); // R5
    AST_FILL_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush) |=> (valid_q != '0)); // R6
    AST_FLUSH_BEATS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && flush) |=> (valid_q == '0)); // R9
endmodule

bind tlb_assoc tlb_assoc_chk #(.ENTRIES(ENTRIES), .FRAME_W(FRAME_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .fill_valid(fill_valid),
    .flush(flush), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_frame(rsp_frame), .valid_q(valid_q), .lk_hits(lk_hits)
);

// File: tb/tlb_assoc_tb.sv
module tlb_assoc_tb_top;
    localparam int N  = 8;
    localparam int SW = 2;
    localparam int PW = 4;
    localparam int FW = 8;
    localparam int NV = 29;
    localparam logic [1:0] OP_LK = 2'd0, OP_FI = 2'd1, OP_FL = 2'd2;

    // {op, seg, page, frame, exp_hit, exp_frame}
    localparam logic [24:0] VEC [NV] = '{
        {OP_LK, 2'd0, 4'd1, 8'h00, 1'b0, 8'h00}, // R1 empty
        {OP_FI, 2'd0, 4'd1, 8'h11, 1'b0, 8'h00}, // R6 -> slot0
        {OP_LK, 2'd0, 4'd1, 8'h00, 1'b1, 8'h11}, // R2
        {OP_LK, 2'd1, 4'd1, 8'h00, 1'b0, 8'h00}, // R8 other segment
        {OP_FI, 2'd1, 4'd1, 8'h21, 1'b0, 8'h00},
        {OP_LK, 2'd1, 4'd1, 8'h00, 1'b1, 8'h21}, // R8
        {OP_LK, 2'd0, 4'd1, 8'h00, 1'b1, 8'h11}, // R8
        {OP_FI, 2'd0, 4'd1, 8'h55, 1'b0, 8'h00}, // R5 rewrite
        {OP_LK, 2'd0, 4'd1, 8'h00, 1'b1, 8'h55}, // R5
        {OP_FI, 2'd2, 4'd0, 8'h30, 1'b0, 8'h00},
        {OP_FI, 2'd2, 4'd1, 8'h31, 1'b0, 8'h00},
        {OP_FI, 2'd2, 4'd2, 8'h32, 1'b0, 8'h00},
        {OP_FI, 2'd2, 4'd3, 8'h33, 1'b0, 8'h00},
        {OP_FI, 2'd2, 4'd4, 8'h34, 1'b0, 8'h00},
        {OP_FI, 2'd2, 4'd5, 8'h35, 1'b0, 8'h00}, // now full
        {OP_LK, 2'd2, 4'd5, 8'h00, 1'b1, 8'h35}, // R2
        {OP_LK, 2'd2, 4'd0, 8'h00, 1'b1, 8'h30}, // R2
        {OP_FI, 2'd3, 4'd0, 8'h40, 1'b0, 8'h00}, // R7 evict slot0
        {OP_LK, 2'd0, 4'd1, 8'h00, 1'b0, 8'h00}, // R7
        {OP_LK, 2'd3, 4'd0, 8'h00, 1'b1, 8'h40}, // R7
        {OP_LK, 2'd1, 4'd1, 8'h00, 1'b1, 8'h21}, // R7
        {OP_FI, 2'd3, 4'd1, 8'h41, 1'b0, 8'h00}, // R7 evict slot1
        {OP_LK, 2'd1, 4'd1, 8'h00, 1'b0, 8'h00}, // R7
        {OP_LK, 2'd3, 4'd1, 8'h00, 1'b1, 8'h41}, // R7
        {OP_FL, 2'd0, 4'd0, 8'h00, 1'b0, 8'h00}, // R4
        {OP_LK, 2'd3, 4'd0, 8'h00, 1'b0, 8'h00}, // R4
        {OP_LK, 2'd2, 4'd0, 8'h00, 1'b0, 8'h00}, // R1
        {OP_FI, 2'd0, 4'd7, 8'h77, 1'b0, 8'h00}, // R6
        {OP_LK, 2'd0, 4'd7, 8'h00, 1'b1, 8'h77}  // R6
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 1'b0, fill_valid = 1'b0, flush = 1'b0;
    logic [SW-1:0] lk_seg = '0, fill_seg = '0;
    logic [PW-1:0] lk_page = '0, fill_page = '0;
    logic [FW-1:0] fill_frame = '0;
    logic rsp_valid, rsp_hit;
    logic [FW-1:0] rsp_frame;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tlb_assoc #(.ENTRIES(N), .SEG_W(SW), .PAGE_W(PW), .FRAME_W(FW), .USE_SEG(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_seg(lk_seg),
        .lk_page(lk_page), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_frame(rsp_frame), .fill_valid(fill_valid), .fill_seg(fill_seg),
        .fill_page(fill_page), .fill_frame(fill_frame), .flush(flush)
    );

    task automatic check(input string tag, input logic ev, input logic eh, input logic [FW-1:0] ef);
        checks++;
        if (rsp_valid !== ev || rsp_hit !== eh || rsp_frame !== ef) begin
            errors++;
            $display("FAIL %s: got valid=%0b hit=%0b frame=%h, expected valid=%0b hit=%0b frame=%h",
                     tag, rsp_valid, rsp_hit, rsp_frame, ev, eh, ef);
        end
    endtask

    // Drive one cycle from a negedge; return at the next negedge.
    task automatic step(input logic lk, input logic fi, input logic fl,
                        input logic [SW-1:0] s, input logic [PW-1:0] p, input logic [FW-1:0] f);
        lk_valid = lk; fill_valid = fi; flush = fl;
        lk_seg = s; lk_page = p; fill_seg = s; fill_page = p; fill_frame = f;
        @(negedge clk);
        lk_valid = 1'b0; fill_valid = 1'b0; flush = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got no finish, expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset state", 1'b0, 1'b0, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [24:0] v;
            v = VEC[i];
            step(v[24:23] == OP_LK, v[24:23] == OP_FI, v[24:23] == OP_FL,
                 v[22:21], v[20:17], v[16:9]);
            if (v[24:23] == OP_LK) check($sformatf("R2 vector %0d", i), 1'b1, v[8], v[7:0]);
            else check($sformatf("R3 no-lookup vector %0d", i), 1'b0, 1'b0, '0);
        end

        // R9: flush and fill together leave the cache empty
        step(1'b0, 1'b1, 1'b1, 2'd3, 4'd3, 8'h99);
        step(1'b1, 1'b0, 1'b0, 2'd3, 4'd3, 8'h00);
        check("R9 flush wins", 1'b1, 1'b0, '0);
        step(1'b1, 1'b0, 1'b0, 2'd0, 4'd7, 8'h00);
        check("R4 flushed key", 1'b1, 1'b0, '0);

        // R3: lookup sees contents before the same-cycle fill
        step(1'b1, 1'b1, 1'b0, 2'd1, 4'd2, 8'h12);
        check("R3 same-cycle fill unseen", 1'b1, 1'b0, '0);
        step(1'b1, 1'b0, 1'b0, 2'd1, 4'd2, 8'h00);
        check("R6 filled after miss", 1'b1, 1'b1, 8'h12);

        // R6/R7: fill slots 1..7, then victim pointer (left at 2) picks slot 2
        for (int k = 3; k <= 9; k++) step(1'b0, 1'b1, 1'b0, 2'd1, PW'(k), FW'(8'h10 + k));
        step(1'b0, 1'b1, 1'b0, 2'd0, 4'd0, 8'hA0);
        step(1'b1, 1'b0, 1'b0, 2'd1, 4'd4, 8'h00);
        check("R7 victim slot2 after flush", 1'b1, 1'b0, '0);
        step(1'b1, 1'b0, 1'b0, 2'd1, 4'd3, 8'h00);
        check("R6 slot1 kept", 1'b1, 1'b1, 8'h13);
        step(1'b1, 1'b0, 1'b0, 2'd0, 4'd0, 8'h00);
        check("R7 new key present", 1'b1, 1'b1, 8'hA0);
        step(1'b0, 1'b1, 1'b0, 2'd0, 4'd14, 8'hA1);
        step(1'b1, 1'b0, 1'b0, 2'd1, 4'd5, 8'h00);
        check("R7 pointer advanced to slot3", 1'b1, 1'b0, '0);
        step(1'b1, 1'b0, 1'b0, 2'd1, 4'd6, 8'h00);
        check("R7 slot4 kept", 1'b1, 1'b1, 8'h16);
        step(1'b1, 1'b0, 1'b0, 2'd3, 4'd6, 8'h00);
        check("R8 segment separates key", 1'b1, 1'b0, '0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule